// File: doc/BRIEF.md
# Row-Hit-First Request Picker

This block chooses which pending memory request a DRAM scheduler should issue next. It scans one queue of request slots. Each slot carries a valid bit, a rank, a bank, a row and a direction flag. The scan also looks at per-bank state: whether a row is open, which row is open, and the earliest cycle at which a read or a write column command may go to that bank. It also takes a per-rank flag that marks ranks not busy with refresh, and a per-rank mask of the banks that can be prepared soonest.

The policy is first-ready, first-come-first-served with two tiers of row hits. A row hit whose column command can issue by the current column deadline is "seamless" and always wins. Any other row hit is "prepped" and beats every non-hit. When the queue holds no hit, the oldest non-hit aimed at one of the soonest-preparable banks is chosen. If the bus direction has just flipped, the column deadline is pushed out by a turnaround allowance. The scheduler pulses a pick strobe. One cycle later the block presents a registered result with a valid pulse, a found flag, the slot index and the tier.

Top module: `rowhit_picker`

## Requirements
- R1: A slot whose valid bit is low, or whose rank has its refresh-idle flag low, is never chosen.
- R2: A slot is a row hit only when its bank has a row open and the open row equals the slot's row. For a hit, the allowed time used is the bank's write-allowed time when the slot's direction flag is 1 (write) and its read-allowed time when it is 0 (read).
- R3: A row hit whose allowed time is less than or equal to the column deadline is seamless. The lowest-index seamless slot is chosen over all other slots, with tier code 3.
- R4: When no seamless hit exists, the lowest-index row hit is chosen with tier code 2, even if a qualifying non-hit sits at a lower index.
- R5: When no row hit exists, the lowest-index non-hit slot whose bank bit is set in its rank's earliest-bank mask is chosen with tier code 1. A non-hit with a clear bank bit is never chosen.
- R6: When no slot qualifies, the result shows found = 0, tier code 0 and index 0.
- R7: The column deadline is the minimum column time plus an allowance. The allowance is 0 when the turnaround input is low. When it is high, the allowance is T_CS for a read queue (queue direction 0) and min(T_RTW, T_CS) for a write queue (queue direction 1).
- R8: The result registers update on the clock edge where the pick strobe is high, and the valid output is high in exactly the following cycle. While the strobe is low, valid is low and found, index and tier hold their values. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pick_i | input | 1 | Strobe: evaluate the queue this cycle |
| turn_i | input | 1 | Bus direction has just changed |
| to_write_i | input | 1 | Queue direction, 1 = write queue |
| ent_valid_i | input | NUM_ENTRIES | Slot occupied flags |
| ent_rank_i | input | NUM_ENTRIES*RANK_W | Per-slot rank, slot i at bits i*RANK_W |
| ent_bank_i | input | NUM_ENTRIES*BANK_W | Per-slot bank |
| ent_row_i | input | NUM_ENTRIES*ROW_W | Per-slot row |
| ent_write_i | input | NUM_ENTRIES | Per-slot direction, 1 = write |
| bank_open_i | input | NUM_RANKS*NUM_BANKS | Row-open flag per bank, index rank*NUM_BANKS+bank |
| open_row_i | input | NUM_RANKS*NUM_BANKS*ROW_W | Open row per bank |
| rd_at_i | input | NUM_RANKS*NUM_BANKS*TIME_W | Earliest read column time per bank |
| wr_at_i | input | NUM_RANKS*NUM_BANKS*TIME_W | Earliest write column time per bank |
| ref_idle_i | input | NUM_RANKS | Rank available (not refreshing) |
| early_bank_i | input | NUM_RANKS*NUM_BANKS | Soonest-preparable bank mask per rank |
| min_col_i | input | TIME_W | Minimum column command time |
| pick_valid_o | output | 1 | Result valid pulse |
| pick_found_o | output | 1 | A slot was chosen |
| pick_idx_o | output | IDX_W | Chosen slot index |
| pick_kind_o | output | 2 | Tier: 0 none, 1 non-hit, 2 prepped, 3 seamless |

## Verification
The bench targets the places where the tier order breaks. It places a prepped hit below a seamless one; a design that stops at the first hit would return the prepped slot. It places a non-hit below a prepped hit; an oldest-first design would take the non-hit. It puts the allowed time exactly on the deadline, with and without the turnaround allowance, in both directions. An off-by-one or a swapped allowance turns seamless into prepped. It also uses a closed bank whose stale row matches, a refresh-busy rank and a write slot with a late write time; a design that ignores the open flag, the rank flag or the direction would report a false hit.

// File: rtl/rowhit_picker_pkg.sv
package rowhit_picker_pkg;
   typedef enum logic [1:0] {
      PK_NONE = 2'd0,
      PK_MISS = 2'd1,
      PK_PREP = 2'd2,
      PK_SEAM = 2'd3
   } pick_kind_e;

   function automatic int min_int(input int a, input int b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/rhp_entry_eval.sv
module rhp_entry_eval #(
   parameter int NUM_RANKS = 2,
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 8,
   parameter int TIME_W    = 8,
   localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int NSLOT    = NUM_RANKS * NUM_BANKS
) (
   input  logic                    valid_i,
   input  logic [RANK_W-1:0]       rank_i,
   input  logic [BANK_W-1:0]       bank_i,
   input  logic [ROW_W-1:0]        row_i,
   input  logic                    write_i,
   input  logic [NSLOT-1:0]        bank_open_i,
   input  logic [NSLOT*ROW_W-1:0]  open_row_i,
   input  logic [NSLOT*TIME_W-1:0] rd_at_i,
   input  logic [NSLOT*TIME_W-1:0] wr_at_i,
   input  logic [NUM_RANKS-1:0]    ref_idle_i,
   input  logic [NSLOT-1:0]        early_bank_i,
   input  logic [TIME_W:0]         deadline_i,
   output logic                    seam_o,
   output logic                    hit_o,
   output logic                    miss_ok_o
);
   localparam int SLOT_W = RANK_W + BANK_W;

   logic [SLOT_W-1:0] slot;
   logic              usable;
   logic              row_match;
   logic [TIME_W-1:0] col_at;

   assign slot   = {rank_i, bank_i};
   assign usable = valid_i && ref_idle_i[rank_i];

   always_comb begin
      row_match = bank_open_i[slot] &&
                  (open_row_i[int'(slot)*ROW_W +: ROW_W] == row_i);
      col_at    = write_i ? wr_at_i[int'(slot)*TIME_W +: TIME_W]
                          : rd_at_i[int'(slot)*TIME_W +: TIME_W];
   end

   assign hit_o     = usable && row_match;
   assign seam_o    = hit_o && ({1'b0, col_at} <= deadline_i);
   assign miss_ok_o = usable && !row_match && early_bank_i[slot];
endmodule

// File: rtl/rhp_first_set.sv
module rhp_first_set #(
   parameter int N     = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rowhit_picker.sv
module rowhit_picker
   import rowhit_picker_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int NUM_RANKS   = 2,
   parameter int NUM_BANKS   = 8,
   parameter int ROW_W       = 8,
   parameter int TIME_W      = 8,
   parameter int T_CS        = 2,
   parameter int T_RTW       = 1,
   localparam int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
   localparam int NSLOT      = NUM_RANKS * NUM_BANKS
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pick_i,
   input  logic                          turn_i,
   input  logic                          to_write_i,
   input  logic [NUM_ENTRIES-1:0]        ent_valid_i,
   input  logic [NUM_ENTRIES*RANK_W-1:0] ent_rank_i,
   input  logic [NUM_ENTRIES*BANK_W-1:0] ent_bank_i,
   input  logic [NUM_ENTRIES*ROW_W-1:0]  ent_row_i,
   input  logic [NUM_ENTRIES-1:0]        ent_write_i,
   input  logic [NSLOT-1:0]              bank_open_i,
   input  logic [NSLOT*ROW_W-1:0]        open_row_i,
   input  logic [NSLOT*TIME_W-1:0]       rd_at_i,
   input  logic [NSLOT*TIME_W-1:0]       wr_at_i,
   input  logic [NUM_RANKS-1:0]          ref_idle_i,
   input  logic [NSLOT-1:0]              early_bank_i,
   input  logic [TIME_W-1:0]             min_col_i,
   output logic                          pick_valid_o,
   output logic                          pick_found_o,
   output logic [IDX_W-1:0]              pick_idx_o,
   output logic [1:0]                    pick_kind_o
);
   localparam int XR_I = T_CS;
   localparam int XW_I = min_int(T_RTW, T_CS);
   localparam logic [TIME_W:0] XR_V = XR_I[TIME_W:0];
   localparam logic [TIME_W:0] XW_V = XW_I[TIME_W:0];

   // elaboration checks on the parameter set
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("rowhit_picker: NUM_ENTRIES must be at least 2");
   end
   if ((NUM_RANKS < 2) || ((NUM_RANKS & (NUM_RANKS - 1)) != 0)) begin : g_bad_ranks
      $error("rowhit_picker: NUM_RANKS must be a power of two, at least 2");
   end
   if ((NUM_BANKS < 2) || ((NUM_BANKS & (NUM_BANKS - 1)) != 0)) begin : g_bad_banks
      $error("rowhit_picker: NUM_BANKS must be a power of two, at least 2");
   end
   if ((T_CS < 0) || (T_RTW < 0) || (T_CS >= (1 << TIME_W))) begin : g_bad_delay
      $error("rowhit_picker: turnaround allowances out of range");
   end

   // column deadline, widened one bit so the allowance cannot wrap
   logic [TIME_W:0] allowance;
   logic [TIME_W:0] deadline;

   always_comb begin
      if (!turn_i)         allowance = '0;
      else if (to_write_i) allowance = XW_V;
      else                 allowance = XR_V;
      deadline = {1'b0, min_col_i} + allowance;
   end

   // per-slot classification
   logic [NUM_ENTRIES-1:0] seam_vec;
   logic [NUM_ENTRIES-1:0] hit_vec;
   logic [NUM_ENTRIES-1:0] miss_vec;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
      rhp_entry_eval #(
         .NUM_RANKS (NUM_RANKS),
         .NUM_BANKS (NUM_BANKS),
         .ROW_W     (ROW_W),
         .TIME_W    (TIME_W)
      ) u_eval (
         .valid_i      (ent_valid_i[e]),
         .rank_i       (ent_rank_i[e*RANK_W +: RANK_W]),
         .bank_i       (ent_bank_i[e*BANK_W +: BANK_W]),
         .row_i        (ent_row_i[e*ROW_W +: ROW_W]),
         .write_i      (ent_write_i[e]),
         .bank_open_i  (bank_open_i),
         .open_row_i   (open_row_i),
         .rd_at_i      (rd_at_i),
         .wr_at_i      (wr_at_i),
         .ref_idle_i   (ref_idle_i),
         .early_bank_i (early_bank_i),
         .deadline_i   (deadline),
         .seam_o       (seam_vec[e]),
         .hit_o        (hit_vec[e]),
         .miss_ok_o    (miss_vec[e])
      );
   end

   // three oldest-first searches run side by side
   logic             seam_any, hit_any, miss_any;
   logic [IDX_W-1:0] seam_idx, hit_idx, miss_idx;

   rhp_first_set #(.N(NUM_ENTRIES)) u_first_seam (
      .vec_i (seam_vec), .any_o (seam_any), .idx_o (seam_idx));
   rhp_first_set #(.N(NUM_ENTRIES)) u_first_hit (
      .vec_i (hit_vec),  .any_o (hit_any),  .idx_o (hit_idx));
   rhp_first_set #(.N(NUM_ENTRIES)) u_first_miss (
      .vec_i (miss_vec), .any_o (miss_any), .idx_o (miss_idx));

   pick_kind_e       nxt_kind;
   logic [IDX_W-1:0] nxt_idx;

   always_comb begin
      if (seam_any) begin
         nxt_kind = PK_SEAM;
         nxt_idx  = seam_idx;
      end else if (hit_any) begin
         nxt_kind = PK_PREP;
         nxt_idx  = hit_idx;
      end else if (miss_any) begin
         nxt_kind = PK_MISS;
         nxt_idx  = miss_idx;
      end else begin
         nxt_kind = PK_NONE;
         nxt_idx  = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pick_valid_o <= 1'b0;
         pick_found_o <= 1'b0;
         pick_idx_o   <= '0;
         pick_kind_o  <= PK_NONE;
      end else begin
         pick_valid_o <= pick_i;
         if (pick_i) begin
            pick_found_o <= (nxt_kind != PK_NONE);
            pick_idx_o   <= nxt_idx;
            pick_kind_o  <= nxt_kind;
         end
      end
   end
endmodule

// File: rtl/rowhit_picker_chk.sv
module rowhit_picker_chk #(
   parameter int NUM_ENTRIES = 8,
   parameter int NUM_RANKS   = 2,
   localparam int RANK_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          pick_i,
   input logic [NUM_ENTRIES-1:0]        ent_valid_i,
   input logic [NUM_ENTRIES*RANK_W-1:0] ent_rank_i,
   input logic [NUM_RANKS-1:0]          ref_idle_i,
   input logic                          pick_valid_o,
   input logic                          pick_found_o,
   input logic [IDX_W-1:0]              pick_idx_o,
   input logic [1:0]                    pick_kind_o
);
   // snapshot of the queue as seen on the strobe edge
   logic [NUM_ENTRIES-1:0]        snap_valid;
   logic [NUM_ENTRIES*RANK_W-1:0] snap_rank;
   logic [NUM_RANKS-1:0]          snap_idle;
   logic [RANK_W-1:0]             chosen_rank;
   logic                          chosen_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_valid <= '0;
         snap_rank  <= '0;
         snap_idle  <= '0;
      end else if (pick_i) begin
         snap_valid <= ent_valid_i;
         snap_rank  <= ent_rank_i;
         snap_idle  <= ref_idle_i;
      end
   end

   always_comb begin
      chosen_rank = snap_rank[int'(pick_idx_o)*RANK_W +: RANK_W];
      chosen_ok   = snap_valid[pick_idx_o] && snap_idle[chosen_rank];
   end

   p_chosen_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid_o && pick_found_o) |-> chosen_ok);

   p_found_has_tier_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pick_found_o |-> (pick_kind_o != 2'd0));

   p_none_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid_o && !pick_found_o) |-> (pick_kind_o == 2'd0 && pick_idx_o == '0));

   p_valid_after_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pick_i |=> pick_valid_o);

   p_quiet_without_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_i |=> !pick_valid_o);

   p_hold_without_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_i |=> ($stable(pick_found_o) && $stable(pick_idx_o) && $stable(pick_kind_o)));
endmodule

bind rowhit_picker rowhit_picker_chk #(
   .NUM_ENTRIES (NUM_ENTRIES),
   .NUM_RANKS   (NUM_RANKS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pick_i       (pick_i),
   .ent_valid_i  (ent_valid_i),
   .ent_rank_i   (ent_rank_i),
   .ref_idle_i   (ref_idle_i),
   .pick_valid_o (pick_valid_o),
   .pick_found_o (pick_found_o),
   .pick_idx_o   (pick_idx_o),
   .pick_kind_o  (pick_kind_o)
);

// File: tb/rowhit_picker_bench.sv
`timescale 1ns/1ps
module rowhit_picker_bench;
   localparam int NE     = 8;
   localparam int NR     = 2;
   localparam int NB     = 8;
   localparam int ROW_W  = 8;
   localparam int TIME_W = 8;
   localparam int T_CS   = 2;
   localparam int T_RTW  = 1;
   localparam int RANK_W = 1;
   localparam int BANK_W = 3;
   localparam int IDX_W  = 3;
   localparam int NS     = NR * NB;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   pick_i = 1'b0;
   logic                   turn_i = 1'b0;
   logic                   to_write_i = 1'b0;
   logic [NE-1:0]          ent_valid_i = '0;
   logic [NE*RANK_W-1:0]   ent_rank_i = '0;
   logic [NE*BANK_W-1:0]   ent_bank_i = '0;
   logic [NE*ROW_W-1:0]    ent_row_i = '0;
   logic [NE-1:0]          ent_write_i = '0;
   logic [NS-1:0]          bank_open_i = '0;
   logic [NS*ROW_W-1:0]    open_row_i = '0;
   logic [NS*TIME_W-1:0]   rd_at_i = '0;
   logic [NS*TIME_W-1:0]   wr_at_i = '0;
   logic [NR-1:0]          ref_idle_i = '1;
   logic [NS-1:0]          early_bank_i = '0;
   logic [TIME_W-1:0]      min_col_i = '0;
   logic                   pick_valid_o;
   logic                   pick_found_o;
   logic [IDX_W-1:0]       pick_idx_o;
   logic [1:0]             pick_kind_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   rowhit_picker #(
      .NUM_ENTRIES (NE), .NUM_RANKS (NR), .NUM_BANKS (NB),
      .ROW_W (ROW_W), .TIME_W (TIME_W), .T_CS (T_CS), .T_RTW (T_RTW)
   ) u_rowhit_picker (
      .clk (clk), .rst_n (rst_n), .pick_i (pick_i), .turn_i (turn_i),
      .to_write_i (to_write_i), .ent_valid_i (ent_valid_i),
      .ent_rank_i (ent_rank_i), .ent_bank_i (ent_bank_i),
      .ent_row_i (ent_row_i), .ent_write_i (ent_write_i),
      .bank_open_i (bank_open_i), .open_row_i (open_row_i),
      .rd_at_i (rd_at_i), .wr_at_i (wr_at_i), .ref_idle_i (ref_idle_i),
      .early_bank_i (early_bank_i), .min_col_i (min_col_i),
      .pick_valid_o (pick_valid_o), .pick_found_o (pick_found_o),
      .pick_idx_o (pick_idx_o), .pick_kind_o (pick_kind_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_all();
      turn_i = 0; to_write_i = 0; ent_valid_i = '0; ent_rank_i = '0;
      ent_bank_i = '0; ent_row_i = '0; ent_write_i = '0; bank_open_i = '0;
      open_row_i = '0; rd_at_i = '0; wr_at_i = '0; ref_idle_i = '1;
      early_bank_i = '0; min_col_i = '0;
   endtask

   task automatic set_ent(input int i, input bit v, input int rk, input int bk,
                          input int rw, input bit wr);
      ent_valid_i[i] = v;
      ent_rank_i[i*RANK_W +: RANK_W] = RANK_W'(rk);
      ent_bank_i[i*BANK_W +: BANK_W] = BANK_W'(bk);
      ent_row_i[i*ROW_W +: ROW_W]    = ROW_W'(rw);
      ent_write_i[i] = wr;
   endtask

   task automatic set_bank(input int rk, input int bk, input bit op, input int orow,
                           input int rd, input int wr, input bit early);
      int s;
      s = rk * NB + bk;
      bank_open_i[s] = op;
      open_row_i[s*ROW_W +: ROW_W] = ROW_W'(orow);
      rd_at_i[s*TIME_W +: TIME_W]  = TIME_W'(rd);
      wr_at_i[s*TIME_W +: TIME_W]  = TIME_W'(wr);
      early_bank_i[s] = early;
   endtask

   // reference: tier order from the requirements
   function automatic void ref_pick(output int f, output int idx, output int kind);
      int dl, seam, hit, miss;
      dl = int'(min_col_i) + (turn_i ? (to_write_i ? ((T_RTW < T_CS) ? T_RTW : T_CS) : T_CS) : 0);
      seam = -1; hit = -1; miss = -1;
      for (int i = 0; i < NE; i++) begin
         int rk, s, t;
         bit is_hit;
         if (!ent_valid_i[i]) continue;
         rk = int'(ent_rank_i[i*RANK_W +: RANK_W]);
         if (!ref_idle_i[rk]) continue;
         s = rk * NB + int'(ent_bank_i[i*BANK_W +: BANK_W]);
         is_hit = bank_open_i[s] && (open_row_i[s*ROW_W +: ROW_W] == ent_row_i[i*ROW_W +: ROW_W]);
         t = ent_write_i[i] ? int'(wr_at_i[s*TIME_W +: TIME_W]) : int'(rd_at_i[s*TIME_W +: TIME_W]);
         if (is_hit) begin
            if (t <= dl && seam < 0) seam = i;
            if (hit < 0) hit = i;
         end else if (early_bank_i[s] && miss < 0) begin
            miss = i;
         end
      end
      if (seam >= 0)      begin f = 1; idx = seam; kind = 3; end
      else if (hit >= 0)  begin f = 1; idx = hit;  kind = 2; end
      else if (miss >= 0) begin f = 1; idx = miss; kind = 1; end
      else                begin f = 0; idx = 0;    kind = 0; end
   endfunction

   // called at a falling edge; returns at the falling edge after the result
   task automatic do_pick(input string req);
      int ef, ei, ek;
      ref_pick(ef, ei, ek);
      pick_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pick_i = 1'b0;
      chk(req, "valid", int'(pick_valid_o), 1);
      chk(req, "found", int'(pick_found_o), ef);
      chk(req, "index", int'(pick_idx_o), ei);
      chk(req, "tier",  int'(pick_kind_o), ek);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      @(negedge clk);
      // reset state
      chk("R8", "reset valid", int'(pick_valid_o), 0);
      chk("R8", "reset found", int'(pick_found_o), 0);
      chk("R8", "reset index", int'(pick_idx_o), 0);
      chk("R8", "reset tier",  int'(pick_kind_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: empty queue
      clear_all();
      do_pick("R6");

      // R3: seamless at 5 beats prepped at 1 and non-hit at 0 (deadline equal)
      clear_all();
      min_col_i = 8'd10;
      set_ent(0, 1, 0, 0, 5, 0); set_bank(0, 0, 1, 7, 0, 0, 1);
      set_ent(1, 1, 0, 1, 3, 0); set_bank(0, 1, 1, 3, 20, 0, 0);
      set_ent(5, 1, 1, 2, 4, 0); set_bank(1, 2, 1, 4, 10, 0, 0);
      do_pick("R3");
      chk("R3", "seamless slot", int'(pick_idx_o), 5);

      // R4: seamless slot one cycle late becomes prepped; lowest hit wins over non-hit at 0
      set_bank(1, 2, 1, 4, 11, 0, 0);
      do_pick("R4");
      chk("R4", "prepped slot", int'(pick_idx_o), 1);

      // R1: rank refresh-busy hides the seamless slot
      set_bank(1, 2, 1, 4, 10, 0, 0);
      ref_idle_i[1] = 1'b0;
      do_pick("R1");
      chk("R1", "busy rank skipped", int'(pick_idx_o), 1);
      // R1: invalid slot skipped
      ent_valid_i[1] = 1'b0;
      do_pick("R1");
      chk("R1", "invalid slot skipped", int'(pick_kind_o), 1);

      // R5: non-hits, mask clear at 0, set at 2 and 4
      clear_all();
      set_ent(0, 1, 0, 3, 1, 0); set_bank(0, 3, 0, 0, 0, 0, 0);
      set_ent(2, 1, 1, 4, 1, 0); set_bank(1, 4, 0, 0, 0, 0, 1);
      set_ent(4, 1, 0, 5, 1, 1); set_bank(0, 5, 0, 0, 0, 0, 1);
      do_pick("R5");
      chk("R5", "oldest masked non-hit", int'(pick_idx_o), 2);
      early_bank_i = '0;
      do_pick("R5");
      chk("R5", "mask clear gives none", int'(pick_found_o), 0);

      // R2: write slot uses write time
      clear_all();
      min_col_i = 8'd10;
      set_ent(0, 1, 0, 0, 2, 1); set_bank(0, 0, 1, 2, 0, 50, 0);
      do_pick("R2");
      chk("R2", "write time late -> prepped", int'(pick_kind_o), 2);
      ent_write_i[0] = 1'b0;
      do_pick("R2");
      chk("R2", "read time early -> seamless", int'(pick_kind_o), 3);
      bank_open_i[0] = 1'b0;
      do_pick("R2");
      chk("R2", "closed bank no hit", int'(pick_found_o), 0);

      // R7: turnaround allowance at the exact boundary
      clear_all();
      min_col_i = 8'd20;
      set_ent(0, 1, 0, 0, 9, 0); set_bank(0, 0, 1, 9, 22, 21, 0);
      do_pick("R7");
      chk("R7", "no turn read", int'(pick_kind_o), 2);
      turn_i = 1'b1;
      do_pick("R7");
      chk("R7", "turn read allowance", int'(pick_kind_o), 3);
      set_bank(0, 0, 1, 9, 23, 21, 0);
      do_pick("R7");
      chk("R7", "turn read one past", int'(pick_kind_o), 2);
      to_write_i = 1'b1; ent_write_i[0] = 1'b1;
      do_pick("R7");
      chk("R7", "turn write allowance", int'(pick_kind_o), 3);
      set_bank(0, 0, 1, 9, 23, 22, 0);
      do_pick("R7");
      chk("R7", "turn write uses smaller allowance", int'(pick_kind_o), 2);

      // R8: no strobe -> valid low, result held while inputs change
      clear_all();
      @(negedge clk);
      chk("R8", "idle valid", int'(pick_valid_o), 0);
      chk("R8", "held tier", int'(pick_kind_o), 2);
      chk("R8", "held found", int'(pick_found_o), 1);

      // random mix
      for (int n = 0; n < 400; n++) begin
         clear_all();
         turn_i     = 1'($urandom_range(0, 1));
         to_write_i = 1'($urandom_range(0, 1));
         min_col_i  = TIME_W'($urandom_range(0, 40));
         ref_idle_i = NR'($urandom_range(0, 3) | (n % 4 == 0 ? 0 : 1));
         for (int r = 0; r < NR; r++)
            for (int b = 0; b < NB; b++)
               set_bank(r, b, 1'($urandom_range(0, 3) != 0), $urandom_range(0, 3),
                        $urandom_range(0, 63), $urandom_range(0, 63),
                        1'($urandom_range(0, 3) == 0));
         for (int i = 0; i < NE; i++)
            set_ent(i, 1'($urandom_range(0, 4) != 0), $urandom_range(0, NR - 1),
                    $urandom_range(0, NB - 1), $urandom_range(0, 3),
                    1'($urandom_range(0, 1)));
         case (n % 4)
            0: do_pick("R3");
            1: do_pick("R4");
            2: do_pick("R5");
            default: do_pick("R1");
         endcase
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule